// File: doc/BRIEF.md
# Multicore Private Peripheral Region Decoder

This block is the register-bus slave for the 8 KB private peripheral window of a small cluster of one to four processors. The `NCPU` parameter sets the processor count. The block holds a small snoop-control bank. It steers every other access to a per-processor interrupt-interface window or to a per-processor timer/watchdog window.

Each per-processor window can be reached in two ways. A self alias selects the processor that issued the access, and that processor is named on the master-ID sideband. A banked address selects the processor explicitly. Banked addresses of processors that are not fitted are masked: reads give zero and writes are dropped. For each accepted access the block reports a target select, a processor index and a local offset. It also returns read data from the selected target. The interrupt controller and the timers are represented by plain register stubs.

Top module: `priv_region_dec`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `req_ready` and `rsp_valid` are low. After reset the control register at offset 0x000 reads zero.
- R2: Offset 0x000 is a read/write control register. It returns the last value written to it.
- R3: Offset 0x004 is read-only. Bits [3:0] read NCPU-1, bits [4+NCPU-1:4] read all ones, and all other bits read zero. Writes to it change nothing.
- R4: Offsets 0x008 and 0x00C always read zero. Writes to them leave the control register unchanged.
- R5: Offsets 0x100–0x1FF select the interrupt interface (`dec_sel`=2) of the processor named by `req_mid`, with local offset addr[7:0]. The interrupt stub stores four words per processor at local offsets 0x0, 0x4, 0x8 and 0xC. Other local offsets read zero and ignore writes.
- R6: Offsets 0x200–0x5FF select the interrupt interface of processor (addr−0x200)>>8.
- R7: Offsets 0x600–0x6FF select the timer unit pair (`dec_sel`=3) of the requesting processor. Offsets 0x700–0xAFF select the pair of processor (addr−0x700)>>8. Address bit 5 picks unit 2·cpu+bit5, and addr[3:2] picks one of four words in that unit.
- R8: If the resolved processor index is NCPU or more, `dec_sel` reads 0. Reads then return zero and writes are dropped.
- R9: Offsets 0x010–0x0FF and 0xB00–0x1FFF store nothing and read zero. Offsets 0x0B00 upward give `dec_sel`=0, and offsets below 0x100 give `dec_sel`=1.
- R10: An accepted request (`req_valid`&&`req_ready`) produces exactly one `rsp_valid` pulse on the next cycle, with `rsp_rdata`, `dec_sel`, `dec_cpu` and `dec_off` for that request. No response is produced without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Block accepts requests |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Byte offset within the window |
| req_mid | input | 2 | Master ID of the requesting processor |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the previous accepted request |
| rsp_rdata | output | 32 | Read data (zero for writes) |
| dec_sel | output | 2 | Target: 0 none, 1 snoop bank, 2 interrupt interface, 3 timers |
| dec_cpu | output | 2 | Resolved processor index |
| dec_off | output | 8 | Local offset, addr[7:0] |

## Verification
Every result of this block (the read data, the target select, the processor index and the local offset) is registered once. It is therefore due exactly one cycle after the edge that accepts the request. The bench drives each request at a falling edge and lets one rising edge accept it. It samples all response outputs at the following falling edge, and then checks that `rsp_valid` has dropped one cycle later when no request follows. Writes update the stubs on the accepting edge, so a read that follows a write by one access already returns the new value. The bench's reference model is updated at the same point.

// File: rtl/priv_region_pkg.sv
// Shared types for the private peripheral region decoder.
package priv_region_pkg;
    // Target selected by one access.
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_SCU  = 2'd1,
        SEL_IRQ  = 2'd2,
        SEL_TMR  = 2'd3
    } tgt_sel_e;

    localparam int MAX_CPU = 4;
    localparam int CPU_W   = 2;
endpackage

// File: rtl/priv_region_map.sv
// Address decoder: resolves offset and master ID into a target, a
// processor index and a local offset.
// Assumes a 13-bit byte offset and NCPU in 1..4.
module priv_region_map
    import priv_region_pkg::*;
#(
    parameter int NCPU   = 1,
    parameter int ADDR_W = 13
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [CPU_W-1:0]  mid,
    output tgt_sel_e          sel,
    output logic [CPU_W-1:0]  cpu,
    output logic [7:0]        off
);
    localparam logic [ADDR_W-1:0] IRQ_SELF = ADDR_W'('h100);
    localparam logic [ADDR_W-1:0] IRQ_BANK = ADDR_W'('h200);
    localparam logic [ADDR_W-1:0] TMR_SELF = ADDR_W'('h600);
    localparam logic [ADDR_W-1:0] TMR_BANK = ADDR_W'('h700);
    localparam logic [ADDR_W-1:0] MAP_END  = ADDR_W'('hB00);

    logic [3:0] idx;
    tgt_sel_e   raw_sel;

    // Region compare and processor index arithmetic.
    always_comb begin
        raw_sel = SEL_NONE;
        idx     = '0;
        if (addr < IRQ_SELF) begin
            raw_sel = SEL_SCU;
        end else if (addr < IRQ_BANK) begin
            raw_sel = SEL_IRQ;
            idx     = {2'b00, mid};
        end else if (addr < TMR_SELF) begin
            raw_sel = SEL_IRQ;
            idx     = addr[11:8] - 4'd2;
        end else if (addr < TMR_BANK) begin
            raw_sel = SEL_TMR;
            idx     = {2'b00, mid};
        end else if (addr < MAP_END) begin
            raw_sel = SEL_TMR;
            idx     = addr[11:8] - 4'd7;
        end
    end

    // Mask processors that are not fitted.
    always_comb begin
        sel = raw_sel;
        if ((raw_sel == SEL_IRQ || raw_sel == SEL_TMR) && idx >= 4'(NCPU))
            sel = SEL_NONE;
        cpu = idx[CPU_W-1:0];
        off = addr[7:0];
    end

    // a_r8_cpu_present: a per-processor target always names a fitted processor.
    always_comb begin
        if (sel == SEL_IRQ || sel == SEL_TMR)
            a_r8_cpu_present: assert (int'(cpu) < NCPU);
    end
endmodule

// File: rtl/priv_scu_bank.sv
// Snoop-control register bank: a read/write control word, a read-only
// configuration word derived from NCPU, and zero-reading status and
// invalidate locations. Assumes wr_en is already qualified by the region.
module priv_scu_bank #(
    parameter int NCPU   = 1,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        off,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam logic [DATA_W-1:0] CFG_WORD =
        DATA_W'((((1 << NCPU) - 1) << 4) | (NCPU - 1));

    logic [DATA_W-1:0] ctrl_q;
    logic              ctrl_we;

    assign ctrl_we = wr_en && (off == 8'h00);

    // Control register storage.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_we) ctrl_q <= wdata;
    end

    // Read mux over the bank.
    always_comb begin
        case (off)
            8'h00:   rdata = ctrl_q;
            8'h04:   rdata = CFG_WORD;
            default: rdata = '0;
        endcase
    end

    // a_r2_ctrl_holds: control changes only on its own write.
    a_r2_ctrl_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_we |=> $stable(ctrl_q));
endmodule

// File: rtl/priv_reg_stub.sv
// Register stub standing in for a downstream slave: NUM_SLOT slots of
// four words each, selected by slot index and word index.
// Assumes the caller only asserts wr_en for a slot that exists.
module priv_reg_stub #(
    parameter int NUM_SLOT = 2,
    parameter int SLOT_W   = 3,
    parameter int DATA_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] slot,
    input  logic [1:0]        word,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [NUM_SLOT][4];

    for (genvar s = 0; s < NUM_SLOT; s++) begin : g_slot
        for (genvar w = 0; w < 4; w++) begin : g_word
            // One stored word.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    mem[s][w] <= '0;
                else if (wr_en && slot == SLOT_W'(s) && word == 2'(w))
                    mem[s][w] <= wdata;
            end
        end
    end

    // Read mux over slots.
    always_comb begin
        rdata = '0;
        for (int s = 0; s < NUM_SLOT; s++)
            if (slot == SLOT_W'(s)) rdata = mem[s][word];
    end

    // a_r8_slot_exists: writes only reach existing slots.
    a_r8_slot_exists: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(slot) < NUM_SLOT));
endmodule

// File: rtl/priv_region_dec.sv
// Private peripheral region decoder: single-cycle register-bus slave
// for the cluster's private window. Registers the decode result and
// the read data one cycle after acceptance. Assumes NCPU in 1..4.
module priv_region_dec
    import priv_region_pkg::*;
#(
    parameter int NCPU   = 1,
    parameter int ADDR_W = 13,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CPU_W-1:0]  req_mid,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [1:0]        dec_sel,
    output logic [CPU_W-1:0]  dec_cpu,
    output logic [7:0]        dec_off
);
    localparam int TMR_SLOTS = 2 * NCPU;
    localparam int SLOT_W    = CPU_W + 1;

    tgt_sel_e          sel;
    logic [CPU_W-1:0]  cpu;
    logic [7:0]        off;
    logic              acc, wr;
    logic              irq_word_ok;
    logic [DATA_W-1:0] scu_rd, irq_rd, tmr_rd, rd_mux;

    assign acc         = req_valid && req_ready;
    assign wr          = acc && req_write;
    assign irq_word_ok = (off[7:4] == 4'h0);

    priv_region_map #(.NCPU(NCPU), .ADDR_W(ADDR_W)) u_map (
        .addr(req_addr), .mid(req_mid), .sel(sel), .cpu(cpu), .off(off)
    );

    priv_scu_bank #(.NCPU(NCPU), .DATA_W(DATA_W)) u_scu (
        .clk(clk), .rst_n(rst_n), .wr_en(wr && sel == SEL_SCU),
        .off(off), .wdata(req_wdata), .rdata(scu_rd)
    );

    priv_reg_stub #(.NUM_SLOT(NCPU), .SLOT_W(SLOT_W), .DATA_W(DATA_W)) u_irq (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr && sel == SEL_IRQ && irq_word_ok),
        .slot({1'b0, cpu}), .word(off[3:2]), .wdata(req_wdata), .rdata(irq_rd)
    );

    priv_reg_stub #(.NUM_SLOT(TMR_SLOTS), .SLOT_W(SLOT_W), .DATA_W(DATA_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .wr_en(wr && sel == SEL_TMR),
        .slot({cpu, off[5]}), .word(off[3:2]), .wdata(req_wdata), .rdata(tmr_rd)
    );

    // Pick read data of the selected target.
    always_comb begin
        case (sel)
            SEL_SCU: rd_mux = scu_rd;
            SEL_IRQ: rd_mux = irq_word_ok ? irq_rd : '0;
            SEL_TMR: rd_mux = tmr_rd;
            default: rd_mux = '0;
        endcase
    end

    // Ready rises one cycle after reset is released.
    always_ff @(posedge clk) begin
        if (!rst_n) req_ready <= 1'b0;
        else        req_ready <= 1'b1;
    end

    // Register the response and decode result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            dec_sel   <= 2'd0;
            dec_cpu   <= '0;
            dec_off   <= '0;
        end else begin
            rsp_valid <= acc;
            if (acc) begin
                rsp_rdata <= req_write ? '0 : rd_mux;
                dec_sel   <= sel;
                dec_cpu   <= cpu;
                dec_off   <= off;
            end
        end
    end

    // a_r10_rsp_follows: each accepted request yields a response next cycle.
    a_r10_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> rsp_valid);
    // a_r10_no_spurious: no response without a request.
    a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> !rsp_valid);
    // a_r8_none_reads_zero: unmapped or masked targets return zero.
    a_r8_none_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && dec_sel == 2'd0) |-> (rsp_rdata == '0));
endmodule

// File: tb/priv_region_dec_tb.sv
// Bench for priv_region_dec with two processors fitted: directed checks
// on the snoop bank, then full sweeps of the window with a reference model.
module priv_region_dec_tb;
    localparam int NCPU = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [12:0] req_addr = '0;
    logic [1:0]  req_mid = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready, rsp_valid;
    logic [31:0] rsp_rdata;
    logic [1:0]  dec_sel, dec_cpu;
    logic [7:0]  dec_off;

    int checks = 0;
    int errors = 0;

    logic [31:0] irq_m [4][4];
    logic [31:0] tmr_m [8][4];
    logic [31:0] ctrl_m;

    always #2 clk = ~clk;

    priv_region_dec #(.NCPU(NCPU)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_mid(req_mid),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .dec_sel(dec_sel), .dec_cpu(dec_cpu), .dec_off(dec_off)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected target and index from the address map.
    function automatic void exp_dec(input logic [12:0] a, input logic [1:0] m,
                                    output int sel, output int cpu);
        sel = 0; cpu = 0;
        if (a < 13'h100)      begin sel = 1; end
        else if (a < 13'h200) begin sel = 2; cpu = m; end
        else if (a < 13'h600) begin sel = 2; cpu = (a - 13'h200) >> 8; end
        else if (a < 13'h700) begin sel = 3; cpu = m; end
        else if (a < 13'hB00) begin sel = 3; cpu = (a - 13'h700) >> 8; end
        if (sel >= 2 && cpu >= NCPU) sel = 0;
    endfunction

    function automatic string tag_of(input logic [12:0] a, input int sel);
        if (sel == 0 && (a < 13'hB00) && a >= 13'h100) return "R8";
        if (sel == 0 || (sel == 1 && a >= 13'h10)) return "R9";
        if (sel == 1) return "R4";
        if (a < 13'h200) return "R5";
        if (a < 13'h600) return "R6";
        return "R7";
    endfunction

    // One access; response sampled one cycle later and checked.
    task automatic access(input logic wr, input logic [12:0] a, input logic [1:0] m,
                          input logic [31:0] d);
        int sel, cpu;
        logic [31:0] exp;
        string tag;
        exp_dec(a, m, sel, cpu);
        tag = tag_of(a, sel);
        exp = '0;
        if (!wr) begin
            case (sel)
                1: exp = (a[7:0] == 8'h00) ? ctrl_m :
                         (a[7:0] == 8'h04) ? 32'h31 : 32'h0;
                2: exp = (a[7:4] == 4'h0) ? irq_m[cpu][a[3:2]] : 32'h0;
                3: exp = tmr_m[cpu*2 + int'(a[5])][a[3:2]];
                default: exp = '0;
            endcase
        end
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_mid = m; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10 rsp_valid", 32'(rsp_valid), 32'd1);
        chk({tag, " sel"}, 32'(dec_sel), 32'(sel));
        if (sel >= 2) chk({tag, " cpu"}, 32'(dec_cpu), 32'(cpu));
        chk({tag, " off"}, 32'(dec_off), 32'(a[7:0]));
        chk({tag, " data"}, rsp_rdata, exp);
        if (wr) begin
            if (sel == 1 && a[7:0] == 8'h00) ctrl_m = d;
            if (sel == 2 && a[7:4] == 4'h0) irq_m[cpu][a[3:2]] = d;
            if (sel == 3) tmr_m[cpu*2 + int'(a[5])][a[3:2]] = d;
        end
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        ctrl_m = '0;
        for (int i = 0; i < 4; i++) for (int j = 0; j < 4; j++) irq_m[i][j] = '0;
        for (int i = 0; i < 8; i++) for (int j = 0; j < 4; j++) tmr_m[i][j] = '0;
        repeat (4) @(negedge clk);
        chk("R1 ready in reset", 32'(req_ready), 32'd0);
        chk("R1 rsp in reset", 32'(rsp_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rsp after reset", 32'(rsp_valid), 32'd0);
        access(1'b0, 13'h000, 2'd0, 32'h0);           // R1 control reads zero
        access(1'b1, 13'h000, 2'd1, 32'hDEAD_BEEF);   // R2
        access(1'b0, 13'h000, 2'd0, 32'h0);
        access(1'b1, 13'h000, 2'd0, 32'h1234_5678);
        access(1'b0, 13'h000, 2'd1, 32'h0);
        access(1'b0, 13'h004, 2'd0, 32'h0);           // R3
        access(1'b1, 13'h004, 2'd0, 32'hFFFF_FFFF);
        access(1'b0, 13'h004, 2'd1, 32'h0);
        access(1'b1, 13'h008, 2'd0, 32'hAAAA_AAAA);   // R4
        access(1'b1, 13'h00C, 2'd0, 32'h5555_5555);
        access(1'b0, 13'h008, 2'd0, 32'h0);
        access(1'b0, 13'h00C, 2'd0, 32'h0);
        access(1'b0, 13'h000, 2'd0, 32'h0);
        @(negedge clk);
        chk("R10 single pulse", 32'(rsp_valid), 32'd0);
        // Sweep of writes, master ID alternating, then reads from both IDs.
        for (int a = 0; a < 8192; a += 4)
            access(1'b1, 13'(a), 2'(a >> 2), {8'h5A, 8'(a >> 2), 3'b0, 13'(a)});
        for (int m = 0; m < 2; m++)
            for (int a = 0; a < 8192; a += 4)
                access(1'b0, 13'(a), 2'(m), 32'h0);
        // Second write pass through the self aliases, then re-read banked.
        for (int m = 0; m < 2; m++)
            for (int a = 'h100; a < 'h700; a += 4)
                if (a < 'h200 || a >= 'h600)
                    access(1'b1, 13'(a), 2'(m), {8'hC3, 8'(m), 3'b0, 13'(a)});
        for (int a = 'h200; a < 'hB00; a += 4)
            access(1'b0, 13'(a), 2'd0, 32'h0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule